// File: doc/BRIEF.md
# Idle-Mode Clock Gating Controller

This block decides what happens to the CPU clock and to the peripheral clock when software asks for sleep with the idle-enable control bit set. Three clock sources can feed the system: primary, secondary low-frequency and internal RC. A 2-bit source select and a vector of secondary-enable bits choose the source that clocks the idle mode. When that source is not the current one, the block first switches to it and waits until it is usable. For the primary this wait is an oscillator startup count, plus an optional PLL lock count. Once in idle, the CPU clock is gated and the peripheral clock keeps running from the chosen source.

A wake strobe starts a fixed CPU-settling count. When it expires, the CPU clock restarts from the source that clocked the peripherals during idle. Two status flags are kept: primary stable and secondary running. The control inputs are never modified by the block, so the same idle mode can be entered again without rewriting them. One down-counter serves the startup, PLL and settling intervals. All gating enables are registered on the falling edge of their source clock, so no gated output can carry a runt pulse. The oscillators themselves are modelled as ready inputs. The source clocks are assumed to be related to `clk_i`.

Top module: `idle_clock_ctrl`

## Requirements
- R1: A sleep strobe with idle enable set, whose target source equals the current source, enters idle on the sampling edge. Idle entry sets `mode_o` to {1, src}, where the source codes are 00 primary, 01 secondary and 10 RC, and run modes are {0, src}. The CPU clock carries no high phase from the next cycle on, while the peripheral clock keeps toggling.
- R2: In primary idle, and after waking from it, `pri_stable_o` stays 1 and the peripheral clock keeps running.
- R3: A select of 01 with at least one secondary-enable bit set switches to the secondary source. The switch completes on the first edge that samples `sec_rdy_i` high, and enters secondary idle on that edge. Completion clears `pri_stable_o` and sets `sec_run_o`.
- R4: A select of 01 with every secondary-enable bit clear performs no switch. It enters the idle mode of the current source (primary idle or RC idle) on the sampling edge.
- R5: A wake strobe sampled in idle on edge k gives the following sequence. `mode_o` keeps the idle code until edge k+SETTLE_CYC, where it returns to the run code. The CPU clock's first high phase follows edge k+SETTLE_CYC+1.
- R6: After wake, the run mode uses the idle source. Both flags keep their idle values, including `sec_run_o`=1 after secondary idle.
- R7: A switch to the primary source (select 00) enters primary idle OST_CYC edges after the sleep edge, counting only edges with `pri_rdy_i` high. With `pll_en_i` set, PLL_LOCK_CYC further edges are added. Completion sets `pri_stable_o` and clears `sec_run_o`.
- R8: A wake strobe that arrives during a source switch is held. It is serviced as if sampled on the first edge after idle entry.
- R9: A sleep strobe with idle enable clear has no effect. So does a wake strobe in run mode, and a sleep strobe while idle or waking.
- R10: A select of 1x switches to the RC source and completes on the first edge that samples `rc_rdy_i` high. Completion clears both flags.
- R11: After reset the mode is primary run, `pri_stable_o`=1, `sec_run_o`=0, and both the CPU and peripheral clocks run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pri_clk_i | input | 1 | Primary source clock |
| sec_clk_i | input | 1 | Secondary source clock |
| rc_clk_i | input | 1 | Internal RC source clock |
| pri_rdy_i | input | 1 | Primary oscillator running |
| sec_rdy_i | input | 1 | Secondary oscillator usable |
| rc_rdy_i | input | 1 | RC oscillator usable |
| pll_en_i | input | 1 | PLL in use on the primary path |
| sec_en_i | input | NUM_SEC_EN | Secondary oscillator enable bits |
| idle_en_i | input | 1 | Sleep request means idle |
| clk_sel_i | input | 2 | Source select |
| sleep_i | input | 1 | Sleep request strobe |
| wake_i | input | 1 | Wake event strobe |
| mode_o | output | 3 | {idle, source} |
| pri_stable_o | output | 1 | Primary stable flag |
| sec_run_o | output | 1 | Secondary running flag |
| cpu_clk_o | output | 1 | Gated CPU clock |
| periph_clk_o | output | 1 | Peripheral clock |

## Verification
A wake strobe and the completion of a source switch can fall close together. The hard case is a wake that arrives during the primary startup count, while the ready input is held low for part of that count. The bench pulses wake in the middle of such a switch and computes two values itself: the edge of idle entry (startup count plus stalled edges) and the later restart edge (one extra edge plus the settling count). The rest of the bench walks all select values, enable states and PLL settings through successive source transitions. Each transition's latency, mode code and flags are predicted arithmetically.

// File: rtl/idle_clk_pkg.sv
package idle_clk_pkg;
  typedef enum logic [1:0] {
    SRC_PRI = 2'b00,
    SRC_SEC = 2'b01,
    SRC_RC  = 2'b10
  } src_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SWITCH,
    ST_IDLE,
    ST_WAKE
  } state_e;

  localparam int NUM_SRC = 3;
endpackage

// File: rtl/idle_clk_gate.sv
module idle_clk_gate #(
  parameter bit RST_EN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic gclk_o
);
  logic en_q;

  // enable changes only while clk_i is low, so gclk_o has no runt
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= RST_EN;
    else         en_q <= en_i;
  end

  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/idle_clk_fsm.sv
module idle_clk_fsm
  import idle_clk_pkg::*;
#(
  parameter int NUM_SEC_EN   = 4,
  parameter int OST_CYC      = 1024,
  parameter int PLL_LOCK_CYC = 256,
  parameter int SETTLE_CYC   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pri_rdy_i,
  input  logic                  sec_rdy_i,
  input  logic                  rc_rdy_i,
  input  logic                  pll_en_i,
  input  logic [NUM_SEC_EN-1:0] sec_en_i,
  input  logic                  idle_en_i,
  input  logic [1:0]            clk_sel_i,
  input  logic                  sleep_i,
  input  logic                  wake_i,
  output src_e                  cur_src_o,
  output logic                  cpu_run_o,
  output logic [2:0]            mode_o,
  output logic                  pri_stable_o,
  output logic                  sec_run_o
);
  localparam int MAX_A = (OST_CYC > PLL_LOCK_CYC) ? OST_CYC : PLL_LOCK_CYC;
  localparam int MAX_C = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] OST_LD    = CNT_W'(OST_CYC - 1);
  localparam logic [CNT_W-1:0] PLL_LD    = CNT_W'(PLL_LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

  state_e           state_q;
  src_e             cur_q, tgt_q, nxt_src;
  logic [CNT_W-1:0] cnt_q;
  logic             pll_ph_q, pend_q, pri_stable_q, sec_run_q;
  logic             sw_done;

  always_comb begin
    unique case (clk_sel_i)
      2'b00:   nxt_src = SRC_PRI;
      2'b01:   nxt_src = (|sec_en_i) ? SRC_SEC : cur_q;  // fallback keeps source
      default: nxt_src = SRC_RC;
    endcase
  end

  always_comb begin
    unique case (tgt_q)
      SRC_SEC: sw_done = sec_rdy_i;
      SRC_RC:  sw_done = rc_rdy_i;
      default: sw_done = pri_rdy_i && (cnt_q == '0) && (pll_ph_q || !pll_en_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_RUN;
      cur_q        <= SRC_PRI;
      tgt_q        <= SRC_PRI;
      cnt_q        <= '0;
      pll_ph_q     <= 1'b0;
      pend_q       <= 1'b0;
      pri_stable_q <= 1'b1;
      sec_run_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (sleep_i && idle_en_i) begin
            if (nxt_src == cur_q) begin
              state_q <= ST_IDLE;
            end else begin
              state_q  <= ST_SWITCH;
              tgt_q    <= nxt_src;
              cnt_q    <= OST_LD;
              pll_ph_q <= 1'b0;
            end
          end
        end
        ST_SWITCH: begin
          if (wake_i) pend_q <= 1'b1;
          if (sw_done) begin
            state_q      <= ST_IDLE;
            cur_q        <= tgt_q;
            pri_stable_q <= (tgt_q == SRC_PRI);
            sec_run_q    <= (tgt_q == SRC_SEC);
          end else if (tgt_q == SRC_PRI && pri_rdy_i) begin
            if (cnt_q != '0) begin
              cnt_q <= cnt_q - 1'b1;
            end else if (!pll_ph_q && pll_en_i) begin
              pll_ph_q <= 1'b1;
              cnt_q    <= PLL_LD;
            end
          end
        end
        ST_IDLE: begin
          if (wake_i || pend_q) begin
            state_q <= ST_WAKE;
            cnt_q   <= SETTLE_LD;
            pend_q  <= 1'b0;
          end
        end
        default: begin
          if (cnt_q == '0) state_q <= ST_RUN;
          else             cnt_q   <= cnt_q - 1'b1;
        end
      endcase
    end
  end

  assign cur_src_o    = cur_q;
  assign cpu_run_o    = (state_q == ST_RUN) || (state_q == ST_SWITCH);
  assign mode_o       = {(state_q == ST_IDLE) || (state_q == ST_WAKE), cur_q};
  assign pri_stable_o = pri_stable_q;
  assign sec_run_o    = sec_run_q;

  assert_sec_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == SRC_SEC) |-> (sec_run_q && !pri_stable_q));

  assert_pri_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == SRC_PRI) |-> pri_stable_q);

  assert_fallback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && sleep_i && idle_en_i && clk_sel_i == 2'b01 && sec_en_i == '0)
      |=> (state_q == ST_IDLE && $stable(cur_q)));

  assert_settle_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && wake_i) |=> (state_q == ST_WAKE && cnt_q == SETTLE_LD));

  assert_wake_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |=> $stable(cur_q));

  assert_pending_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && pend_q) |=> (state_q == ST_WAKE));

  assert_run_ignores_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !sleep_i) |=> (state_q == ST_RUN && $stable(cur_q)));
endmodule

// File: rtl/idle_clock_ctrl.sv
module idle_clock_ctrl
  import idle_clk_pkg::*;
#(
  parameter int NUM_SEC_EN   = 4,
  parameter int OST_CYC      = 1024,
  parameter int PLL_LOCK_CYC = 256,
  parameter int SETTLE_CYC   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pri_clk_i,
  input  logic                  sec_clk_i,
  input  logic                  rc_clk_i,
  input  logic                  pri_rdy_i,
  input  logic                  sec_rdy_i,
  input  logic                  rc_rdy_i,
  input  logic                  pll_en_i,
  input  logic [NUM_SEC_EN-1:0] sec_en_i,
  input  logic                  idle_en_i,
  input  logic [1:0]            clk_sel_i,
  input  logic                  sleep_i,
  input  logic                  wake_i,
  output logic [2:0]            mode_o,
  output logic                  pri_stable_o,
  output logic                  sec_run_o,
  output logic                  cpu_clk_o,
  output logic                  periph_clk_o
);
  src_e               cur_src;
  logic               cpu_run;
  logic [NUM_SRC-1:0] src_clk, per_en, cpu_en, per_g, cpu_g;

  assign src_clk = {rc_clk_i, sec_clk_i, pri_clk_i};

  idle_clk_fsm #(
    .NUM_SEC_EN  (NUM_SEC_EN),
    .OST_CYC     (OST_CYC),
    .PLL_LOCK_CYC(PLL_LOCK_CYC),
    .SETTLE_CYC  (SETTLE_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pri_rdy_i   (pri_rdy_i),
    .sec_rdy_i   (sec_rdy_i),
    .rc_rdy_i    (rc_rdy_i),
    .pll_en_i    (pll_en_i),
    .sec_en_i    (sec_en_i),
    .idle_en_i   (idle_en_i),
    .clk_sel_i   (clk_sel_i),
    .sleep_i     (sleep_i),
    .wake_i      (wake_i),
    .cur_src_o   (cur_src),
    .cpu_run_o   (cpu_run),
    .mode_o      (mode_o),
    .pri_stable_o(pri_stable_o),
    .sec_run_o   (sec_run_o)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign per_en[s] = (cur_src == src_e'(s));
    assign cpu_en[s] = per_en[s] && cpu_run;

    idle_clk_gate #(.RST_EN(s == 0)) u_per_gate (
      .clk_i (src_clk[s]),
      .rst_ni(rst_ni),
      .en_i  (per_en[s]),
      .gclk_o(per_g[s])
    );

    idle_clk_gate #(.RST_EN(s == 0)) u_cpu_gate (
      .clk_i (src_clk[s]),
      .rst_ni(rst_ni),
      .en_i  (cpu_en[s]),
      .gclk_o(cpu_g[s])
    );
  end

  assign periph_clk_o = |per_g;
  assign cpu_clk_o    = |cpu_g;

  assert_one_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(per_en) && (cpu_en & ~per_en) == '0);
endmodule

// File: tb/test_idle_clock_ctrl.sv
module test_idle_clock_ctrl;
  localparam int NSE = 4;
  localparam int OST = 1024;
  localparam int PLL = 256;
  localparam int SET = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pri_rdy = 1'b1, sec_rdy = 1'b1, rc_rdy = 1'b1, pll_en = 1'b0;
  logic [NSE-1:0] sec_en = '0;
  logic idle_en = 1'b0, sleep = 1'b0, wake = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [2:0] mode;
  logic pri_stable, sec_run, cpu_clk, per_clk;

  int errors = 0, checks = 0, cyc = 0;
  int cur = 0;

  always #4 clk = ~clk;  // 125 MHz; all source clocks share it

  idle_clock_ctrl #(
    .NUM_SEC_EN(NSE), .OST_CYC(OST), .PLL_LOCK_CYC(PLL), .SETTLE_CYC(SET)
  ) i_idle_clock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pri_clk_i(clk), .sec_clk_i(clk), .rc_clk_i(clk),
    .pri_rdy_i(pri_rdy), .sec_rdy_i(sec_rdy), .rc_rdy_i(rc_rdy), .pll_en_i(pll_en),
    .sec_en_i(sec_en), .idle_en_i(idle_en), .clk_sel_i(sel), .sleep_i(sleep),
    .wake_i(wake), .mode_o(mode), .pri_stable_o(pri_stable), .sec_run_o(sec_run),
    .cpu_clk_o(cpu_clk), .periph_clk_o(per_clk)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp=<150000", cyc);
      summary();
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic check_flags(string req, int src);
    check(req, pri_stable, (src == 0) ? 1 : 0);
    check(req, sec_run, (src == 1) ? 1 : 0);
  endtask

  task automatic pulse_sleep(logic [1:0] s, logic [NSE-1:0] se, logic ie);
    sel = s; sec_en = se; idle_en = ie; sleep = 1'b1;
    step();
    sleep = 1'b0;
  endtask

  // wake, count edges until run code, then see the CPU clock come back
  task automatic do_wake(string req, int src);
    int n = 0;
    wake = 1'b1;
    step();
    wake = 1'b0;
    while (mode[2] && n < 100) begin step(); n++; end
    check(req, n, SET);
    check(req, int'(mode), src);
    step();
    check(req, cpu_clk, 1);
  endtask

  initial begin
    int tgt, lat, sv;
    logic [NSE-1:0] se;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    check("R11", int'(mode), 0);
    check_flags("R11", 0);
    check("R11", cpu_clk, 1);
    check("R11", per_clk, 1);

    // R9 sleep with idle enable clear, wake in run
    pulse_sleep(2'b10, 4'b0001, 1'b0);
    step();
    check("R9", int'(mode), 0);
    check("R9", cpu_clk, 1);
    wake = 1'b1; step(); wake = 1'b0; step();
    check("R9", int'(mode), 0);
    check("R9", cpu_clk, 1);

    // R3 secondary switch waits for ready
    sec_rdy = 1'b0;
    pulse_sleep(2'b01, 4'b0100, 1'b1);
    repeat (3) step();
    check("R3", int'(mode), 0);
    sec_rdy = 1'b1;
    step();
    check("R3", int'(mode), 5);
    check_flags("R3", 1);
    step();
    check("R1", cpu_clk, 0);
    check("R1", per_clk, 1);
    // R9 sleep while idle is ignored
    pulse_sleep(2'b10, 4'b0100, 1'b1);
    step();
    check("R9", int'(mode), 5);
    do_wake("R5", 1);
    check_flags("R6", 1);
    cur = 1;

    // sweep: select x enable x PLL across successive sources
    for (int rep = 0; rep < 3; rep++) begin
      for (int si = 0; si < 4; si++) begin
        for (int ei = 0; ei < 2; ei++) begin
          for (int pi = 0; pi < 2; pi++) begin
            sv = (rep == 0) ? si : 3 - si;
            pll_en = (rep == 1) ? 1'(1 - pi) : 1'(pi);
            se = ei ? NSE'(1 << (si % NSE)) : '0;
            tgt = (sv == 0) ? 0 : (sv == 1) ? (ei ? 1 : cur) : 2;
            lat = (tgt == cur) ? 0 : (tgt == 0) ? OST + (pll_en ? PLL : 0) : 1;
            pulse_sleep(2'(sv), se, 1'b1);
            for (int i = 1; i <= lat; i++) begin
              if (i == lat) check((tgt == 0) ? "R7" : (tgt == 2) ? "R10" : "R3",
                                  int'(mode), cur);
              step();
            end
            check((sv == 1 && ei == 0) ? "R4" : (tgt == 0) ? "R7" : "R1",
                  int'(mode), 4 + tgt);
            check_flags((tgt == 2) ? "R10" : (tgt == 0) ? "R2" : "R3", tgt);
            step();
            check("R1", cpu_clk, 0);
            check("R2", per_clk, 1);
            cur = tgt;
            do_wake("R5", tgt);
            check_flags("R6", tgt);
          end
        end
      end
    end

    // R8 wake held during primary startup with ready stalled
    pll_en = 1'b0;
    pulse_sleep(2'b10, '0, 1'b1);
    if (cur != 2) step();
    do_wake("R10", 2);
    pri_rdy = 1'b0;
    pulse_sleep(2'b00, '0, 1'b1);
    repeat (5) step();
    pri_rdy = 1'b1;
    begin
      int n = 0;
      for (int i = 6; i <= OST + 5; i++) begin
        if (i == 10) wake = 1'b1;
        if (i == OST + 5) check("R7", int'(mode), 2);
        step();
        wake = 1'b0;
      end
      check("R8", int'(mode), 4);
      check_flags("R7", 0);
      while (mode[2] && n < 100) begin step(); n++; end
      check("R8", n, SET + 1);
      step();
      check("R8", cpu_clk, 1);
    end
    summary();
  end
endmodule